// File: doc/BRIEF.md
# Masked-Write Digital Edge Capture Bank

This block watches a bank of general-purpose digital input pins. It synchronizes each one and can record a chosen transition on any channel that has capture logic. All channels share one interrupt line. Each channel has four settings or status bits: a polarity bit that picks which edge counts, a capture-enable bit, an interrupt-enable bit, and a sticky captured flag. The channels are grouped into words of `DATA_W` bits, and software reaches them through a plain register read/write port.

Capture enables are never written as plain data. Software first sets a single global command bit to the value it wants (1 to arm, 0 to disarm). It then writes the enable word, and that value is applied only to the channels whose data bits are 1. Disarming a channel is the only way to clear its captured flag, and the clear also removes any interrupt that flag was causing. A parameter mask marks the channel positions that have no capture logic. Those positions always read 0.

The address is `{word index, field}`. The field codes are: 0 input levels (read only), 1 polarity, 2 interrupt enable, 3 capture enable, 4 captured flags (read only), 5 global command (bit 0). Writes to read-only or unused fields have no effect. Reads of unused fields return 0.

Top module: `ecb_bank`

## Requirements
- R1: In a channel with capture armed, a polarity bit of 1 captures a sensed 0-to-1 transition and a polarity bit of 0 captures a sensed 1-to-0 transition. The other transition direction leaves the flag unchanged.
- R2: A write to the capture-enable field (code 3) loads the global command bit (field code 5, bit 0) into every channel whose data bit is 1. Channels whose data bit is 0 keep their previous enable. The stored enables read back unchanged from field code 3.
- R3: A captured flag can be set only while that channel's capture is armed. Once set, it reads 1 in field code 4 until it is cleared.
- R4: A flag stays set until its channel is disarmed. Disarming clears the flag and any interrupt it was causing. A disarmed channel captures nothing until it is armed again.
- R5: An edge is captured even when the channel's interrupt enable (field code 2) is 0. In that case the captured flag does not raise the interrupt.
- R6: `irq_o` is 1 exactly when at least one channel, in any word, has both its flag and its interrupt enable set.
- R7: Channel positions cleared in `HW_MASK` ignore writes to the polarity, interrupt-enable and capture-enable fields. Their bits in those fields and in the flag field always read 0.
- R8: Input sense is inverted. A high pin reads 0 in field code 0 and a low pin reads 1. The value read lags a pin change by two clock edges of synchronization.
- R9: Reset clears the polarity, interrupt-enable, capture-enable and flag bits, the global command bit, and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_CH | Raw pin levels, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address {word index, 3-bit field} |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` are stable around each rising clock edge. They also assume that a pin holds each level for at least three clocks, so the synchronizer sees every transition the checks rely on. The stimulus changes pins and bus signals only at falling edges. After each pin change it waits four clocks before reading the flags. Register writes are separated from pin changes, so no edge arrives in the same cycle as the write that arms its channel.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

    localparam int FLD_W = 3;

    typedef enum logic [FLD_W-1:0] {
        FLD_PINS = 3'd0,
        FLD_POL  = 3'd1,
        FLD_IEN  = 3'd2,
        FLD_CEN  = 3'd3,
        FLD_FLAG = 3'd4,
        FLD_CMD  = 3'd5
    } fld_e;

    typedef struct packed {
        logic pol;
        logic ien;
        logic cen;
        logic cmd;
    } wr_strobe_t;

    function automatic int bank_bits(input int nb);
        return (nb > 1) ? $clog2(nb) : 1;
    endfunction

    function automatic wr_strobe_t decode_wr(input logic wr, input fld_e f);
        wr_strobe_t s;
        s.pol = wr && (f == FLD_POL);
        s.ien = wr && (f == FLD_IEN);
        s.cen = wr && (f == FLD_CEN);
        s.cmd = wr && (f == FLD_CMD);
        return s;
    endfunction

endpackage

// File: rtl/ecb_sync.sv
module ecb_sync #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pin_i,
    output logic [NUM_CH-1:0] level_o,
    output logic [NUM_CH-1:0] prev_o
);
    logic [NUM_CH-1:0] stage1;
    logic [NUM_CH-1:0] stage2;
    logic [NUM_CH-1:0] stage3;

    // Inverted sense: a pin pulled low is a logical 1.
    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
            stage3 <= '0;
        end else begin
            stage1 <= ~pin_i;
            stage2 <= stage1;
            stage3 <= stage2;
        end
    end

    assign level_o = stage2;
    assign prev_o  = stage3;
endmodule

// File: rtl/ecb_regif.sv
module ecb_regif import ecb_pkg::*; #(
    parameter int              NUM_CH  = 32,
    parameter int              DATA_W  = 16,
    parameter logic [NUM_CH-1:0] HW_MASK = '1,
    localparam int NUM_BANKS = NUM_CH / DATA_W,
    localparam int BANK_W    = bank_bits(NUM_BANKS),
    localparam int ADDR_W    = BANK_W + FLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0] level,
    input  logic [NUM_CH-1:0] cap_en,
    input  logic [NUM_CH-1:0] flags,
    output logic [NUM_CH-1:0] pol_o,
    output logic [NUM_CH-1:0] ien_o,
    output logic [NUM_CH-1:0] cen_mask_o,
    output logic              cen_cmd_o,
    output logic [DATA_W-1:0] rdata
);
    logic [BANK_W-1:0] bank;
    fld_e              fld;
    wr_strobe_t        stb;
    logic              cmd_q;

    assign bank = addr[ADDR_W-1:FLD_W];
    assign fld  = fld_e'(addr[FLD_W-1:0]);
    assign stb  = decode_wr(wr_en, fld);

    always_ff @(posedge clk) begin
        if (rst)          cmd_q <= 1'b0;
        else if (stb.cmd) cmd_q <= wdata[0];
    end
    assign cen_cmd_o = cmd_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = b * DATA_W;
        localparam logic [DATA_W-1:0] HW = HW_MASK[LO +: DATA_W];
        logic              hit;
        logic [DATA_W-1:0] pol_q;
        logic [DATA_W-1:0] ien_q;

        assign hit = (bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                pol_q <= '0;
                ien_q <= '0;
            end else begin
                if (stb.pol && hit) pol_q <= wdata & HW;
                if (stb.ien && hit) ien_q <= wdata & HW;
            end
        end

        assign pol_o[LO +: DATA_W]      = pol_q;
        assign ien_o[LO +: DATA_W]      = ien_q;
        assign cen_mask_o[LO +: DATA_W] = (stb.cen && hit) ? (wdata & HW) : '0;
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank == BANK_W'(b)) begin
                case (fld)
                    FLD_PINS: rdata = level[b*DATA_W +: DATA_W];
                    FLD_POL:  rdata = pol_o[b*DATA_W +: DATA_W];
                    FLD_IEN:  rdata = ien_o[b*DATA_W +: DATA_W];
                    FLD_CEN:  rdata = cap_en[b*DATA_W +: DATA_W];
                    FLD_FLAG: rdata = flags[b*DATA_W +: DATA_W];
                    FLD_CMD:  rdata = {{(DATA_W-1){1'b0}}, cmd_q};
                    default:  rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/ecb_capture.sv
module ecb_capture #(
    parameter int                NUM_CH  = 32,
    parameter logic [NUM_CH-1:0] HW_MASK = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] level,
    input  logic [NUM_CH-1:0] prev,
    input  logic [NUM_CH-1:0] pol,
    input  logic [NUM_CH-1:0] cen_mask,
    input  logic              cen_cmd,
    output logic [NUM_CH-1:0] cap_en_o,
    output logic [NUM_CH-1:0] flag_o
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        if (HW_MASK[i]) begin : g_hw
            logic en_q;
            logic flag_q;
            logic en_d;
            logic hit;

            always_comb begin
                en_d = cen_mask[i] ? cen_cmd : en_q;
                hit  = pol[i] ? (level[i] & ~prev[i]) : (~level[i] & prev[i]);
            end

            // Flag survives only while the channel stays armed.
            always_ff @(posedge clk) begin
                if (rst) begin
                    en_q   <= 1'b0;
                    flag_q <= 1'b0;
                end else begin
                    en_q   <= en_d;
                    flag_q <= en_d & (flag_q | (en_q & hit));
                end
            end

            assign cap_en_o[i] = en_q;
            assign flag_o[i]   = flag_q;
        end else begin : g_none
            logic unused_in;
            assign unused_in   = ^{level[i], prev[i], pol[i], cen_mask[i]};
            assign cap_en_o[i] = 1'b0;
            assign flag_o[i]   = 1'b0;
        end
    end
endmodule

// File: rtl/ecb_bank.sv
module ecb_bank import ecb_pkg::*; #(
    parameter int                NUM_CH  = 32,
    parameter int                DATA_W  = 16,
    parameter logic [NUM_CH-1:0] HW_MASK = 32'hFF0F_FFFF,
    localparam int NUM_BANKS = NUM_CH / DATA_W,
    localparam int ADDR_W    = bank_bits(NUM_BANKS) + FLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o
);
    logic [NUM_CH-1:0] level;
    logic [NUM_CH-1:0] prev;
    logic [NUM_CH-1:0] pol;
    logic [NUM_CH-1:0] ien;
    logic [NUM_CH-1:0] cen_mask;
    logic              cen_cmd;
    logic [NUM_CH-1:0] cap_en;
    logic [NUM_CH-1:0] flags;

    ecb_sync #(.NUM_CH(NUM_CH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (pin_i),
        .level_o (level),
        .prev_o  (prev)
    );

    ecb_regif #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .HW_MASK(HW_MASK)) u_regif (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .level      (level),
        .cap_en     (cap_en),
        .flags      (flags),
        .pol_o      (pol),
        .ien_o      (ien),
        .cen_mask_o (cen_mask),
        .cen_cmd_o  (cen_cmd),
        .rdata      (rdata)
    );

    ecb_capture #(.NUM_CH(NUM_CH), .HW_MASK(HW_MASK)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .level    (level),
        .prev     (prev),
        .pol      (pol),
        .cen_mask (cen_mask),
        .cen_cmd  (cen_cmd),
        .cap_en_o (cap_en),
        .flag_o   (flags)
    );

    assign irq_o = |(flags & ien);
endmodule

// File: rtl/ecb_bank_chk.sv
module ecb_bank_chk #(
    parameter int                NUM_CH  = 32,
    parameter logic [NUM_CH-1:0] HW_MASK = '1
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] cap_en,
    input logic [NUM_CH-1:0] flags,
    input logic [NUM_CH-1:0] ien,
    input logic [NUM_CH-1:0] pol,
    input logic [NUM_CH-1:0] cen_mask,
    input logic              irq
);
    AST_MASK_KEEPS_REST: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (((cap_en ^ $past(cap_en)) & ~$past(cen_mask)) == '0)); // R2

    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (flags & ~cap_en) == '0); // R3

    AST_FLAG_SET_WHILE_ARMED: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((flags & ~$past(flags) & ~$past(cap_en)) == '0)); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(flags) & ~flags & cap_en) == '0)); // R4

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0)); // R5

    AST_NO_HW_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((cap_en | flags | ien | pol) & ~HW_MASK) == '0); // R7
endmodule

bind ecb_bank ecb_bank_chk #(.NUM_CH(NUM_CH), .HW_MASK(HW_MASK)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .flags    (flags),
    .ien      (ien),
    .pol      (pol),
    .cen_mask (cen_mask),
    .irq      (irq_o)
);

// File: tb/sim_ecb_bank.sv
module sim_ecb_bank;
    localparam int NUM_CH = 32;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;

    localparam logic [1:0] OP_W = 2'd0; // write addr <- val
    localparam logic [1:0] OP_P = 2'd1; // drive pins = val, wait
    localparam logic [1:0] OP_R = 2'd2; // read addr, expect val
    localparam logic [1:0] OP_I = 2'd3; // expect irq_o = val[0]

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [31:0] val;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 40;
    localparam step_t STEPS [NSTEP] = '{
        '{OP_W, 4'h5, 32'h0000_0001, 4'd2},
        '{OP_W, 4'h1, 32'h0000_000F, 4'd1},
        '{OP_W, 4'h3, 32'h0000_0003, 4'd2},
        '{OP_R, 4'h3, 32'h0000_0003, 4'd2},  // R2 arm ch0,1
        '{OP_W, 4'h5, 32'h0000_0000, 4'd2},
        '{OP_W, 4'h3, 32'h0000_0002, 4'd2},
        '{OP_R, 4'h3, 32'h0000_0001, 4'd2},  // R2 masked disarm of ch1 only
        '{OP_W, 4'h5, 32'h0000_0001, 4'd2},
        '{OP_P, 4'h0, 32'hFFFF_FFFC, 4'd3},
        '{OP_R, 4'h4, 32'h0000_0001, 4'd3},  // R3 ch0 captured, ch1 unarmed
        '{OP_I, 4'h0, 32'h0000_0000, 4'd5},  // R5 no irq without enable
        '{OP_W, 4'h2, 32'h0000_0001, 4'd5},
        '{OP_I, 4'h0, 32'h0000_0001, 4'd6},  // R6
        '{OP_P, 4'h0, 32'hFFFF_FFFF, 4'd4},
        '{OP_R, 4'h4, 32'h0000_0001, 4'd4},  // R4 sticky
        '{OP_W, 4'h3, 32'h0000_0010, 4'd2},
        '{OP_P, 4'h0, 32'hFFFF_FFEF, 4'd1},
        '{OP_R, 4'h4, 32'h0000_0001, 4'd1},  // R1 falling-only ignores rise
        '{OP_P, 4'h0, 32'hFFFF_FFFF, 4'd1},
        '{OP_R, 4'h4, 32'h0000_0011, 4'd1},  // R1 fall captured
        '{OP_W, 4'h5, 32'h0000_0000, 4'd4},
        '{OP_W, 4'h3, 32'h0000_0001, 4'd4},
        '{OP_R, 4'h3, 32'h0000_0010, 4'd2},  // R2
        '{OP_R, 4'h4, 32'h0000_0010, 4'd4},  // R4 disarm clears flag
        '{OP_I, 4'h0, 32'h0000_0000, 4'd4},  // R4 disarm clears irq
        '{OP_P, 4'h0, 32'hFFFF_FFFE, 4'd4},
        '{OP_R, 4'h4, 32'h0000_0010, 4'd4},  // R4 no capture when disarmed
        '{OP_P, 4'h0, 32'hFFFF_FFFF, 4'd4},
        '{OP_W, 4'h5, 32'h0000_0001, 4'd7},
        '{OP_W, 4'hA, 32'h0000_FFFF, 4'd7},
        '{OP_R, 4'hA, 32'h0000_FF0F, 4'd7},  // R7
        '{OP_W, 4'h9, 32'h0000_00F0, 4'd7},
        '{OP_R, 4'h9, 32'h0000_0000, 4'd7},  // R7
        '{OP_W, 4'hB, 32'h0000_00F1, 4'd7},
        '{OP_R, 4'hB, 32'h0000_0001, 4'd7},  // R7
        '{OP_P, 4'h0, 32'hFFEE_FFFF, 4'd7},
        '{OP_P, 4'h0, 32'hFFFF_FFFF, 4'd7},
        '{OP_R, 4'hC, 32'h0000_0001, 4'd7},  // R7 ch20 never flags
        '{OP_I, 4'h0, 32'h0000_0001, 4'd6},  // R6 irq from second word
        '{OP_R, 4'h0, 32'h0000_0000, 4'd8}   // R8 high pins read 0
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_CH-1:0] pin_i = '1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ecb_bank u0 (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pin_i),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq_o (irq_o)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input int req, input logic [3:0] a, input logic [15:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, {16'h0, rdata}, {16'h0, exp});
    endtask

    task automatic pins(input logic [31:0] v);
        @(negedge clk);
        pin_i = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic irq_chk(input int req, input logic exp);
        @(negedge clk);
        #1;
        check(req, {31'h0, irq_o}, {31'h0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd_chk(9, 4'h1, 16'h0);
        rd_chk(9, 4'h2, 16'h0);
        rd_chk(9, 4'h3, 16'h0);
        rd_chk(9, 4'h4, 16'h0);
        rd_chk(9, 4'h5, 16'h0);
        irq_chk(9, 1'b0);

        for (int i = 0; i < NSTEP; i++) begin
            case (STEPS[i].op)
                OP_W: wr(STEPS[i].addr, STEPS[i].val[15:0]);
                OP_P: pins(STEPS[i].val);
                OP_R: rd_chk(int'(STEPS[i].req), STEPS[i].addr, STEPS[i].val[15:0]);
                default: irq_chk(int'(STEPS[i].req), STEPS[i].val[0]);
            endcase
        end

        // R8 inverted sense, both words
        pins(32'hFFFD_FFFE);
        rd_chk(8, 4'h0, 16'h0001);
        rd_chk(8, 4'h8, 16'h0002);
        pins(32'hFFFF_FFFF);

        // R9 mid-run reset clears armed state, flags, command and irq
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd_chk(9, 4'h3, 16'h0);
        rd_chk(9, 4'h4, 16'h0);
        rd_chk(9, 4'hA, 16'h0);
        rd_chk(9, 4'h5, 16'h0);
        irq_chk(9, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule